// File: doc/BRIEF.md
# Sub-Array Tile Execution Controller

This controller accepts matrix-multiply descriptors and runs each one as a series of tiles on a logical sub-array of a systolic fabric. Each accepted descriptor takes an entry in a small region table. The entry records the row window the region covers, the output buffer it writes, its dataflow mode and the number of tiles. The entry then moves through a lifecycle of free, ready, running and complete. Every tile passes through four fixed stages in a fixed order: weight load, first feed, second feed and drain.

All four stages share one stage pipeline that advances once per beat, and a beat is a fixed number of clock cycles. A tile's tag goes with it from stage to stage: its region, tile index, mode and a last-tile flag. The load/store side and the array therefore receive each command together with its context, and nothing is broadcast separately. Tiles from different regions can sit side by side in the pipeline. Within one region, the weight load of the next tile waits until the previous tile has left its feed stages, and it overlaps that tile's drain. The boundary buffer used by each stage depends on the dataflow mode.

Top module: `tec_tile_ctrl`

## Requirements
- R1: After reset, every region state reads free (code 0). No stage slot is valid, `desc_rdy` is high and `done_vld` is low.
- R2: A descriptor is taken on a cycle where `desc_vld` and `desc_rdy` are both high. It goes to the lowest-numbered free entry, whose index is shown on `desc_rid` during that cycle. From the next cycle the entry reads ready (code 1).
- R3: `desc_rdy` is low when all `NREG` entries are occupied. A descriptor offered then is not taken, and no region state changes because of it.
- R4: A beat lasts `STAGE_LEN` cycles. The beat counter starts at zero on reset release. `stg_go` is high exactly in the first cycle of each beat.
- R5: Slot index 0 is weight load, 1 is first feed, 2 is second feed and 3 is drain. At each beat boundary the content of slot s moves to slot s+1 together with its region and tile tags. Slot contents hold still during a beat. An empty slot shows region 0 and tile 0.
- R6: At each beat boundary, slot 0 takes the next tile of the lowest-numbered region that meets three conditions. It is ready or running. It has tiles left to issue. It has no tile in slot 0 or slot 1 before the boundary. Tiles are issued in order from index 0.
- R7: A region running alone starts successive weight loads exactly 3 beats apart. The next weight load shares a beat with the previous tile's drain.
- R8: A region reads running (code 2) from the beat in which its first tile enters slot 0.
- R9: A region enters complete (code 3) when the drain beat of its last tile ends. It stays there for exactly one cycle, during which `done_vld` is high and `done_rid` shows the region index. In the following cycle it reads free.
- R10: `stg_dst` gives each slot a 2-bit boundary code: 0 for the top buffer, 1 for the left buffer, 3 for the output buffer. For weight load the code is 0 in mode 0 (output-stationary) and 1 in mode 1 (input-stationary). For both feeds it is 1 in mode 0 and 0 in mode 1. For drain it is 3. An empty slot gives 0.
- R11: While slot 0 is valid, `cfg_lo`, `cfg_hi` and `cfg_buf` show that region's row bounds and buffer. Otherwise they are 0.
- R12: The tile-count field `desc_ntm1` holds the number of tiles minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_vld | input | 1 | Descriptor offered |
| desc_rdy | output | 1 | A free region entry exists |
| desc_rid | output | RID_W | Entry the offered descriptor would take |
| desc_mode | input | 1 | Dataflow: 0 output-stationary, 1 input-stationary |
| desc_lo | input | ROW_W | First row of the region window |
| desc_hi | input | ROW_W | Last row of the region window |
| desc_buf | input | BUF_W | Output buffer allocated to the region |
| desc_ntm1 | input | TILE_W | Tile count minus one |
| stg_go | output | 1 | First cycle of a beat |
| stg_vld | output | 4 | Slot occupied, per stage |
| stg_rid | output | 4*RID_W | Region tag, per stage |
| stg_tile | output | 4*TILE_W | Tile index, per stage |
| stg_dst | output | 8 | Boundary buffer code, per stage |
| cfg_lo | output | ROW_W | Row window start for the weight-load tile |
| cfg_hi | output | ROW_W | Row window end for the weight-load tile |
| cfg_buf | output | BUF_W | Output buffer for the weight-load tile |
| done_vld | output | 1 | Region completion pulse |
| done_rid | output | RID_W | Region that completed |
| rg_state | output | 2*NREG | Lifecycle code per region |

## Verification
A taken descriptor appears in `rg_state` one cycle after the accepting edge. Stage slots change only at the edge that closes a beat, so new contents show in the cycle where `stg_go` is high. A completion shows one cycle after the edge that closes the last drain beat, and the entry reads free one cycle after that. The bench runs a reference model of these rules that updates on the rising edge, using inputs driven on the falling edge. It compares every output with the model on the falling edge, so each result is read in the cycle it is due. The directed solo runs count cycles between weight-load starts to confirm the three-beat spacing.

// File: rtl/tec_pkg.sv
package tec_pkg;
   typedef enum logic [1:0] {
      RG_FREE  = 2'd0,
      RG_READY = 2'd1,
      RG_RUN   = 2'd2,
      RG_CMPL  = 2'd3
   } rg_state_e;

   localparam int unsigned NSTG = 4;

   localparam logic [1:0] DST_TOP  = 2'd0;
   localparam logic [1:0] DST_LEFT = 2'd1;
   localparam logic [1:0] DST_OUT  = 2'd3;
endpackage

// File: rtl/tec_lowest.sv
module tec_lowest #(
   parameter int unsigned N  = 8,
   parameter int unsigned IW = 3
) (
   input  logic [N-1:0]  req,
   output logic          hit,
   output logic [IW-1:0] idx
);
   always_comb begin
      hit = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/tec_region_table.sv
module tec_region_table
   import tec_pkg::*;
#(
   parameter int unsigned NREG   = 8,
   parameter int unsigned RID_W  = 3,
   parameter int unsigned ROW_W  = 6,
   parameter int unsigned BUF_W  = 3,
   parameter int unsigned TILE_W = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  alloc_en,
   input  logic [RID_W-1:0]      alloc_idx,
   input  logic                  a_mode,
   input  logic [ROW_W-1:0]      a_lo,
   input  logic [ROW_W-1:0]      a_hi,
   input  logic [BUF_W-1:0]      a_buf,
   input  logic [TILE_W-1:0]     a_ntm1,
   input  logic                  iss_en,
   input  logic [RID_W-1:0]      iss_idx,
   input  logic                  drn_en,
   input  logic [RID_W-1:0]      drn_idx,
   output logic [NREG-1:0]       free_vec,
   output logic [NREG-1:0]       elig_vec,
   output logic [NREG-1:0]       last_vec,
   output logic [NREG-1:0]       cmpl_vec,
   output logic [NREG-1:0]       mode_vec,
   output logic [2*NREG-1:0]     state_flat,
   output logic [NREG*ROW_W-1:0] lo_flat,
   output logic [NREG*ROW_W-1:0] hi_flat,
   output logic [NREG*BUF_W-1:0] buf_flat,
   output logic [NREG*TILE_W-1:0] next_flat
);
   localparam int unsigned CNT_W = TILE_W + 1;

   for (genvar e = 0; e < NREG; e++) begin : g_ent
      rg_state_e          st_q;
      logic               mode_q;
      logic [ROW_W-1:0]   lo_q, hi_q;
      logic [BUF_W-1:0]   buf_q;
      logic [TILE_W-1:0]  ntm1_q;
      logic [CNT_W-1:0]   iss_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q   <= RG_FREE;
            mode_q <= 1'b0;
            lo_q   <= '0;
            hi_q   <= '0;
            buf_q  <= '0;
            ntm1_q <= '0;
            iss_q  <= '0;
         end else begin
            if (st_q == RG_CMPL) st_q <= RG_FREE;
            if (alloc_en && alloc_idx == RID_W'(e)) begin
               st_q   <= RG_READY;
               mode_q <= a_mode;
               lo_q   <= a_lo;
               hi_q   <= a_hi;
               buf_q  <= a_buf;
               ntm1_q <= a_ntm1;
               iss_q  <= '0;
            end
            if (iss_en && iss_idx == RID_W'(e)) begin
               st_q  <= RG_RUN;
               iss_q <= iss_q + 1'b1;
            end
            if (drn_en && drn_idx == RID_W'(e)) st_q <= RG_CMPL;
         end
      end

      assign free_vec[e] = (st_q == RG_FREE);
      assign cmpl_vec[e] = (st_q == RG_CMPL);
      assign elig_vec[e] = ((st_q == RG_READY) || (st_q == RG_RUN)) &&
                           (iss_q <= {1'b0, ntm1_q});
      assign last_vec[e] = (iss_q == {1'b0, ntm1_q});
      assign mode_vec[e] = mode_q;
      assign state_flat[2*e +: 2]           = st_q;
      assign lo_flat[e*ROW_W +: ROW_W]      = lo_q;
      assign hi_flat[e*ROW_W +: ROW_W]      = hi_q;
      assign buf_flat[e*BUF_W +: BUF_W]     = buf_q;
      assign next_flat[e*TILE_W +: TILE_W]  = iss_q[TILE_W-1:0];
   end
endmodule

// File: rtl/tec_stage_pipe.sv
module tec_stage_pipe
   import tec_pkg::*;
#(
   parameter int unsigned RID_W     = 3,
   parameter int unsigned ROW_W     = 6,
   parameter int unsigned BUF_W     = 3,
   parameter int unsigned TILE_W    = 4,
   parameter int unsigned STAGE_LEN = 4,
   localparam int unsigned CW = (STAGE_LEN > 1) ? $clog2(STAGE_LEN) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_vld,
   input  logic [RID_W-1:0]         in_rid,
   input  logic [TILE_W-1:0]        in_tile,
   input  logic                     in_mode,
   input  logic                     in_last,
   input  logic [ROW_W-1:0]         in_lo,
   input  logic [ROW_W-1:0]         in_hi,
   input  logic [BUF_W-1:0]         in_buf,
   output logic                     adv,
   output logic                     go,
   output logic [NSTG-1:0]          s_vld,
   output logic [NSTG*RID_W-1:0]    s_rid_flat,
   output logic [NSTG*TILE_W-1:0]   s_tile_flat,
   output logic [NSTG-1:0]          s_mode,
   output logic [NSTG-1:0]          s_last,
   output logic [ROW_W-1:0]         c_lo,
   output logic [ROW_W-1:0]         c_hi,
   output logic [BUF_W-1:0]         c_buf
);
   logic [CW-1:0]     cnt_q;
   logic [RID_W-1:0]  rid_q  [NSTG];
   logic [TILE_W-1:0] tile_q [NSTG];

   assign adv = (cnt_q == CW'(STAGE_LEN - 1));
   assign go  = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= adv ? '0 : cnt_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_vld  <= '0;
         s_mode <= '0;
         s_last <= '0;
         c_lo   <= '0;
         c_hi   <= '0;
         c_buf  <= '0;
         for (int s = 0; s < NSTG; s++) begin
            rid_q[s]  <= '0;
            tile_q[s] <= '0;
         end
      end else if (adv) begin
         for (int s = NSTG - 1; s > 0; s--) begin
            s_vld[s]  <= s_vld[s-1];
            s_mode[s] <= s_mode[s-1];
            s_last[s] <= s_last[s-1];
            rid_q[s]  <= rid_q[s-1];
            tile_q[s] <= tile_q[s-1];
         end
         s_vld[0]  <= in_vld;
         s_mode[0] <= in_mode;
         s_last[0] <= in_last;
         rid_q[0]  <= in_rid;
         tile_q[0] <= in_tile;
         c_lo      <= in_lo;
         c_hi      <= in_hi;
         c_buf     <= in_buf;
      end
   end

   for (genvar s = 0; s < NSTG; s++) begin : g_flat
      assign s_rid_flat[s*RID_W +: RID_W]    = rid_q[s];
      assign s_tile_flat[s*TILE_W +: TILE_W] = tile_q[s];
   end
endmodule

// File: rtl/tec_tile_ctrl.sv
module tec_tile_ctrl
   import tec_pkg::*;
#(
   parameter int unsigned NREG      = 8,
   parameter int unsigned ROW_W     = 6,
   parameter int unsigned BUF_W     = 3,
   parameter int unsigned TILE_W    = 4,
   parameter int unsigned STAGE_LEN = 4,
   localparam int unsigned RID_W = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   desc_vld,
   output logic                   desc_rdy,
   output logic [RID_W-1:0]       desc_rid,
   input  logic                   desc_mode,
   input  logic [ROW_W-1:0]       desc_lo,
   input  logic [ROW_W-1:0]       desc_hi,
   input  logic [BUF_W-1:0]       desc_buf,
   input  logic [TILE_W-1:0]      desc_ntm1,
   output logic                   stg_go,
   output logic [3:0]             stg_vld,
   output logic [4*RID_W-1:0]     stg_rid,
   output logic [4*TILE_W-1:0]    stg_tile,
   output logic [7:0]             stg_dst,
   output logic [ROW_W-1:0]       cfg_lo,
   output logic [ROW_W-1:0]       cfg_hi,
   output logic [BUF_W-1:0]       cfg_buf,
   output logic                   done_vld,
   output logic [RID_W-1:0]       done_rid,
   output logic [2*NREG-1:0]      rg_state
);
   if (NREG < 2 || NREG > 64) begin : g_bad_nreg
      $error("tec_tile_ctrl: NREG must lie in 2..64");
   end
   if (STAGE_LEN < 2) begin : g_bad_len
      $error("tec_tile_ctrl: STAGE_LEN must be at least 2");
   end
   if (TILE_W < 1 || ROW_W < 1 || BUF_W < 1) begin : g_bad_w
      $error("tec_tile_ctrl: field widths must be positive");
   end

   logic [NREG-1:0]        free_vec, elig_vec, last_vec, cmpl_vec, mode_vec, blk_vec;
   logic [NREG*ROW_W-1:0]  lo_flat, hi_flat;
   logic [NREG*BUF_W-1:0]  buf_flat;
   logic [NREG*TILE_W-1:0] next_flat;
   logic                   iss_hit, adv;
   logic [RID_W-1:0]       iss_idx;
   logic [3:0]             s_mode, s_last;
   logic                   alloc_en, iss_en, drn_en;
   logic                   done_hit;

   tec_lowest #(.N(NREG), .IW(RID_W)) u_free_pick (
      .req(free_vec), .hit(desc_rdy), .idx(desc_rid)
   );

   always_comb begin
      blk_vec = '0;
      for (int r = 0; r < NREG; r++) begin
         if (stg_vld[0] && stg_rid[0 +: RID_W] == RID_W'(r))     blk_vec[r] = 1'b1;
         if (stg_vld[1] && stg_rid[RID_W +: RID_W] == RID_W'(r)) blk_vec[r] = 1'b1;
      end
   end

   tec_lowest #(.N(NREG), .IW(RID_W)) u_iss_pick (
      .req(elig_vec & ~blk_vec), .hit(iss_hit), .idx(iss_idx)
   );

   tec_lowest #(.N(NREG), .IW(RID_W)) u_done_pick (
      .req(cmpl_vec), .hit(done_hit), .idx(done_rid)
   );
   assign done_vld = done_hit;

   assign alloc_en = desc_vld && desc_rdy;
   assign iss_en   = adv && iss_hit;
   assign drn_en   = adv && stg_vld[3] && s_last[3];

   tec_region_table #(
      .NREG(NREG), .RID_W(RID_W), .ROW_W(ROW_W), .BUF_W(BUF_W), .TILE_W(TILE_W)
   ) u_table (
      .clk(clk), .rst_n(rst_n),
      .alloc_en(alloc_en), .alloc_idx(desc_rid),
      .a_mode(desc_mode), .a_lo(desc_lo), .a_hi(desc_hi), .a_buf(desc_buf),
      .a_ntm1(desc_ntm1),
      .iss_en(iss_en), .iss_idx(iss_idx),
      .drn_en(drn_en), .drn_idx(stg_rid[3*RID_W +: RID_W]),
      .free_vec(free_vec), .elig_vec(elig_vec), .last_vec(last_vec),
      .cmpl_vec(cmpl_vec), .mode_vec(mode_vec), .state_flat(rg_state),
      .lo_flat(lo_flat), .hi_flat(hi_flat), .buf_flat(buf_flat),
      .next_flat(next_flat)
   );

   tec_stage_pipe #(
      .RID_W(RID_W), .ROW_W(ROW_W), .BUF_W(BUF_W), .TILE_W(TILE_W),
      .STAGE_LEN(STAGE_LEN)
   ) u_pipe (
      .clk(clk), .rst_n(rst_n),
      .in_vld(iss_hit),
      .in_rid(iss_hit ? iss_idx : '0),
      .in_tile(iss_hit ? next_flat[iss_idx*TILE_W +: TILE_W] : '0),
      .in_mode(iss_hit && mode_vec[iss_idx]),
      .in_last(iss_hit && last_vec[iss_idx]),
      .in_lo(iss_hit ? lo_flat[iss_idx*ROW_W +: ROW_W] : '0),
      .in_hi(iss_hit ? hi_flat[iss_idx*ROW_W +: ROW_W] : '0),
      .in_buf(iss_hit ? buf_flat[iss_idx*BUF_W +: BUF_W] : '0),
      .adv(adv), .go(stg_go),
      .s_vld(stg_vld), .s_rid_flat(stg_rid), .s_tile_flat(stg_tile),
      .s_mode(s_mode), .s_last(s_last),
      .c_lo(cfg_lo), .c_hi(cfg_hi), .c_buf(cfg_buf)
   );

   for (genvar s = 0; s < 4; s++) begin : g_dst
      if (s == 0) begin : g_wl
         assign stg_dst[2*s +: 2] = !stg_vld[s] ? 2'd0 :
                                    (s_mode[s] ? DST_LEFT : DST_TOP);
      end else if (s == 3) begin : g_dr
         assign stg_dst[2*s +: 2] = stg_vld[s] ? DST_OUT : 2'd0;
      end else begin : g_fd
         assign stg_dst[2*s +: 2] = !stg_vld[s] ? 2'd0 :
                                    (s_mode[s] ? DST_TOP : DST_LEFT);
      end
   end
endmodule

// File: rtl/tec_tile_ctrl_chk.sv
module tec_tile_ctrl_chk #(
   parameter int unsigned NREG = 8,
   localparam int unsigned RID_W = (NREG > 1) ? $clog2(NREG) : 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               stg_go,
   input logic [3:0]         stg_vld,
   input logic [4*RID_W-1:0] stg_rid,
   input logic               done_vld,
   input logic [RID_W-1:0]   done_rid,
   input logic [2*NREG-1:0]  rg_state
);
   AST_GO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      stg_go |=> !stg_go); // R4
   AST_SLOT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      !stg_go |-> ($stable(stg_vld) && $stable(stg_rid))); // R5
   AST_STAGE_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      stg_go |-> (stg_vld[1] == $past(stg_vld[0]) &&
                  stg_rid[RID_W +: RID_W] == $past(stg_rid[0 +: RID_W]))); // R5
   AST_WL_FF_APART: assert property (@(posedge clk) disable iff (!rst_n)
      (stg_vld[0] && stg_vld[1]) |->
         (stg_rid[0 +: RID_W] != stg_rid[RID_W +: RID_W])); // R6
   AST_WL_FS_APART: assert property (@(posedge clk) disable iff (!rst_n)
      (stg_vld[0] && stg_vld[2]) |->
         (stg_rid[0 +: RID_W] != stg_rid[2*RID_W +: RID_W])); // R6
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_vld |=> !done_vld); // R9
   AST_DONE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      done_vld |=> (rg_state[$past(done_rid)*2 +: 2] == 2'd0)); // R9
endmodule

bind tec_tile_ctrl tec_tile_ctrl_chk #(.NREG(NREG)) u_chk (
   .clk(clk), .rst_n(rst_n), .stg_go(stg_go), .stg_vld(stg_vld),
   .stg_rid(stg_rid), .done_vld(done_vld), .done_rid(done_rid),
   .rg_state(rg_state)
);

// File: tb/tb_tec_tile_ctrl.sv
`timescale 1ns/1ps
module tb_tec_tile_ctrl;
   localparam int NREG = 8, RID_W = 3, ROW_W = 6, BUF_W = 3, TILE_W = 4, LEN = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic desc_vld = 1'b0, desc_mode = 1'b0;
   logic [ROW_W-1:0] desc_lo = '0, desc_hi = '0;
   logic [BUF_W-1:0] desc_buf = '0;
   logic [TILE_W-1:0] desc_ntm1 = '0;
   logic desc_rdy, stg_go, done_vld;
   logic [RID_W-1:0] desc_rid, done_rid;
   logic [3:0] stg_vld;
   logic [4*RID_W-1:0] stg_rid;
   logic [4*TILE_W-1:0] stg_tile;
   logic [7:0] stg_dst;
   logic [ROW_W-1:0] cfg_lo, cfg_hi;
   logic [BUF_W-1:0] cfg_buf;
   logic [2*NREG-1:0] rg_state;

   always #4 clk = ~clk;

   tec_tile_ctrl #(.NREG(NREG), .ROW_W(ROW_W), .BUF_W(BUF_W), .TILE_W(TILE_W),
                   .STAGE_LEN(LEN)) dut (.*);

   int n_chk = 0, n_err = 0, wd = 0;
   logic run_chk = 1'b0;

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int exp_dst(int s, int v, int md);
      if (v == 0) return 0;
      if (s == 3) return 3;
      if (s == 0) return md ? 1 : 0;
      return md ? 0 : 1;
   endfunction

   // reference model, beat level, from the requirements
   int m_st[NREG], m_mode[NREG], m_lo[NREG], m_hi[NREG], m_buf[NREG], m_ntm1[NREG], m_iss[NREG];
   int ms_vld[4], ms_rid[4], ms_tile[4], ms_mode[4], ms_last[4];
   int mc_lo, mc_hi, mc_buf, m_cnt;

   always @(posedge clk) begin
      int pk, fr;
      bit adv;
      if (!rst_n) begin
         m_cnt = 0; mc_lo = 0; mc_hi = 0; mc_buf = 0;
         for (int r = 0; r < NREG; r++) begin
            m_st[r] = 0; m_iss[r] = 0;
         end
         for (int s = 0; s < 4; s++) begin
            ms_vld[s] = 0; ms_rid[s] = 0; ms_tile[s] = 0; ms_mode[s] = 0; ms_last[s] = 0;
         end
      end else begin
         adv = (m_cnt == LEN - 1);
         m_cnt = adv ? 0 : m_cnt + 1;
         pk = -1; fr = -1;
         for (int r = 0; r < NREG; r++) begin
            if (fr < 0 && m_st[r] == 0) fr = r;
            if (adv && pk < 0 && (m_st[r] == 1 || m_st[r] == 2) && m_iss[r] <= m_ntm1[r] &&
                !(ms_vld[0] != 0 && ms_rid[0] == r) && !(ms_vld[1] != 0 && ms_rid[1] == r))
               pk = r;
         end
         for (int r = 0; r < NREG; r++) if (m_st[r] == 3) m_st[r] = 0;
         if (adv) begin
            if (ms_vld[3] != 0 && ms_last[3] != 0) m_st[ms_rid[3]] = 3;
            for (int s = 3; s > 0; s--) begin
               ms_vld[s] = ms_vld[s-1]; ms_rid[s] = ms_rid[s-1]; ms_tile[s] = ms_tile[s-1];
               ms_mode[s] = ms_mode[s-1]; ms_last[s] = ms_last[s-1];
            end
            if (pk >= 0) begin
               ms_vld[0] = 1; ms_rid[0] = pk; ms_tile[0] = m_iss[pk]; ms_mode[0] = m_mode[pk];
               ms_last[0] = (m_iss[pk] == m_ntm1[pk]);
               mc_lo = m_lo[pk]; mc_hi = m_hi[pk]; mc_buf = m_buf[pk];
               m_st[pk] = 2; m_iss[pk]++;
            end else begin
               ms_vld[0] = 0; ms_rid[0] = 0; ms_tile[0] = 0; ms_mode[0] = 0; ms_last[0] = 0;
               mc_lo = 0; mc_hi = 0; mc_buf = 0;
            end
         end
         if (desc_vld && fr >= 0) begin
            m_st[fr] = 1; m_mode[fr] = desc_mode; m_lo[fr] = desc_lo; m_hi[fr] = desc_hi;
            m_buf[fr] = desc_buf; m_ntm1[fr] = desc_ntm1; m_iss[fr] = 0;
         end
      end
   end

   always @(negedge clk) begin
      int fr, dn;
      if (rst_n && run_chk) begin
         fr = -1; dn = -1;
         for (int r = 0; r < NREG; r++) begin
            if (fr < 0 && m_st[r] == 0) fr = r;
            if (dn < 0 && m_st[r] == 3) dn = r;
            chk("R2/R8", "rg_state", rg_state[2*r +: 2], m_st[r]);
         end
         chk("R3", "desc_rdy", desc_rdy, fr >= 0);
         if (fr >= 0) chk("R2", "desc_rid", desc_rid, fr);
         chk("R4", "stg_go", stg_go, m_cnt == 0);
         for (int s = 0; s < 4; s++) begin
            chk("R5", "stg_vld", stg_vld[s], ms_vld[s]);
            chk("R6", "stg_rid", stg_rid[s*RID_W +: RID_W], ms_rid[s]);
            chk("R6", "stg_tile", stg_tile[s*TILE_W +: TILE_W], ms_tile[s]);
            chk("R10", "stg_dst", stg_dst[2*s +: 2], exp_dst(s, ms_vld[s], ms_mode[s]));
         end
         chk("R11", "cfg_lo", cfg_lo, mc_lo);
         chk("R11", "cfg_hi", cfg_hi, mc_hi);
         chk("R11", "cfg_buf", cfg_buf, mc_buf);
         chk("R9", "done_vld", done_vld, dn >= 0);
         if (dn >= 0) chk("R9", "done_rid", done_rid, dn);
      end
   end

   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         n_err++;
         $display("FAIL watchdog (all requirements): got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   task automatic send(input bit md, input int lo, input int hi, input int bf, input int nt);
      desc_vld = 1'b1; desc_mode = md; desc_lo = ROW_W'(lo); desc_hi = ROW_W'(hi);
      desc_buf = BUF_W'(bf); desc_ntm1 = TILE_W'(nt);
      while (!desc_rdy) @(negedge clk);
      @(negedge clk);
      desc_vld = 1'b0;
   endtask

   task automatic run_solo(input bit md, input int nt);
      int cyc, last, nwl;
      cyc = 0; last = 0; nwl = 0;
      send(md, 3, 10, 5, nt);
      while (!done_vld) begin
         @(negedge clk);
         cyc++;
         if (stg_go && stg_vld[0]) begin
            if (nwl > 0) chk("R7", "weight-load spacing", cyc - last, 3 * LEN);
            last = cyc;
            nwl++;
         end
      end
      chk("R12", "tiles run", nwl, nt + 1);
   endtask

   task automatic wait_idle();
      int k;
      k = 0;
      while (rg_state != '0 && k < 5000) begin
         @(negedge clk);
         k++;
      end
   endtask

   initial begin
      void'($urandom(32'h5A1E));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      chk("R1", "rg_state", rg_state, 0);
      chk("R1", "stg_vld", stg_vld, 0);
      chk("R1", "desc_rdy", desc_rdy, 1);
      chk("R1", "done_vld", done_vld, 0);
      run_chk = 1'b1;

      run_solo(1'b0, 2);
      @(negedge clk);
      run_solo(1'b1, 0);
      wait_idle();

      // fill every entry, then offer one more while full (R3)
      for (int i = 0; i < NREG; i++) send(i[0], i, i + 20, i, 15);
      desc_vld = 1'b1; desc_ntm1 = 4'd1;
      repeat (6) @(negedge clk);
      desc_vld = 1'b0;
      wait_idle();

      // constrained random traffic
      for (int i = 0; i < 4000; i++) begin
         desc_vld  = ($urandom % 4) == 0;
         desc_mode = $urandom % 2;
         desc_lo   = ROW_W'($urandom);
         desc_hi   = ROW_W'($urandom);
         desc_buf  = BUF_W'($urandom);
         desc_ntm1 = (($urandom % 8) == 0) ? 4'd15 : TILE_W'($urandom % 4);
         @(negedge clk);
      end
      desc_vld = 1'b0;
      wait_idle();
      chk("R9", "all regions freed", rg_state, 0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule